// File: doc/BRIEF.md
# Dual-Rail Iterative Magnitude Comparator

This block compares two unsigned operands that arrive one bit at a time in dual-rail form. Each bit travels on a pair of wires, a "true" wire and a "false" wire. The pair 00 is the spacer, meaning the bit has not arrived yet. Exactly one wire high is a valid bit, and 11 is never applied. No clock decides when the answer is ready. The answer's validity is read from the codes themselves.

A row of identical cells, one per bit position, carries a comparison state from the most significant position toward the least significant. The state moves on three one-hot wires: equal-so-far, greater, and less. All three low means "unresolved". A cell that receives greater or less passes it on unchanged. A cell that receives equal-so-far resolves from its own bit pair once that pair leaves the spacer. The last cell in the row drives the result, and a completion control raises a done flag once the result can no longer change.

When every input pair returns to the spacer, all result wires and the done flag return to 0, which readies the block for the next evaluation.

Top module: `dr_mag_cmp`

## Requirements
- R1: With every input pair at spacer (true=0, false=0), the outputs ltOut, eqOut, gtOut and doneOut are all 0.
- R2: Once every pair holds a valid code (bit value 1 is true=1,false=0; bit value 0 is true=0,false=1), exactly one of ltOut, eqOut and gtOut is 1, and it matches the unsigned integer comparison of A with B.
- R3: gtOut (or ltOut) rises with doneOut as soon as every pair from the most significant position down to the highest differing position is valid, whatever the state of the lower pairs.
- R4: While any pair at or above the highest differing position is at spacer (or any pair at all when A equals B), ltOut, eqOut, gtOut and doneOut are all 0.
- R5: eqOut is 1 only when every pair is valid and A equals B bit for bit.
- R6: At most one of ltOut, eqOut and gtOut is 1 at any time, and doneOut is 1 exactly when one of them is 1.
- R7: As pairs return to spacer in any order, the outputs follow the state of the remaining valid prefix, and once all pairs are at spacer every output is 0.
- R8: While the remaining pairs are still arriving, a result that has been signalled with doneOut stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aTrue | input | WIDTH | True rails of operand A |
| aFalse | input | WIDTH | False rails of operand A |
| bTrue | input | WIDTH | True rails of operand B |
| bFalse | input | WIDTH | False rails of operand B |
| ltOut | output | 1 | A is less than B |
| eqOut | output | 1 | A equals B |
| gtOut | output | 1 | A is greater than B |
| doneOut | output | 1 | Result is valid and final |

## Verification
The block has no registers, so every result is due in the same clock period as the pair change that causes it. The bench changes one pair shortly after a rising edge and samples on the following falling edge, so each sample sees settled logic. At every arrival step and every return step, the bench compares all four outputs with a prefix model of the relation. When arrival is complete, it also checks the result against the integer comparison. Arrival orders are random, most-significant-first and least-significant-first, so early completion and its absence are both exercised.

// File: rtl/dr_cmp_pkg.sv
package dr_cmp_pkg;

  // Inter-cell state, one wire per resolved value; all zero = unresolved
  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } cmpState_t;

  // Strobes from the completion control to the output stage
  typedef struct packed {
    logic allValid;
    logic decided;
    logic done;
  } doneStrobes_t;

  localparam cmpState_t CHAIN_SEED = '{eq: 1'b1, gt: 1'b0, lt: 1'b0};

  function automatic logic railValid(input logic t, input logic f);
    return t | f;
  endfunction

endpackage

// File: rtl/dr_cmp_cell.sv
module dr_cmp_cell
  import dr_cmp_pkg::*;
(
  input  cmpState_t stIn,
  input  logic      aT,
  input  logic      aF,
  input  logic      bT,
  input  logic      bF,
  output cmpState_t stOut,
  output logic      pairValid
);
  logic aHigher;
  logic bHigher;
  logic bitSame;

  always_comb begin
    aHigher = aT & bF;
    bHigher = aF & bT;
    bitSame = (aT & bT) | (aF & bF);
    stOut.gt = stIn.gt | (stIn.eq & aHigher);
    stOut.lt = stIn.lt | (stIn.eq & bHigher);
    stOut.eq = stIn.eq & bitSame;
    pairValid = railValid(aT, aF) & railValid(bT, bF);
  end
endmodule

// File: rtl/dr_cmp_chain.sv
module dr_cmp_chain
  import dr_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] aTrue,
  input  logic [WIDTH-1:0] aFalse,
  input  logic [WIDTH-1:0] bTrue,
  input  logic [WIDTH-1:0] bFalse,
  output cmpState_t        finalSt,
  output logic [WIDTH-1:0] pairValid
);
  localparam int LINKS = WIDTH + 1;

  cmpState_t link [LINKS];

  assign link[WIDTH] = CHAIN_SEED;

  // Most significant cell first; each cell feeds the next lower one
  for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_cell
    dr_cmp_cell u_cell (
      .stIn     (link[i+1]),
      .aT       (aTrue[i]),
      .aF       (aFalse[i]),
      .bT       (bTrue[i]),
      .bF       (bFalse[i]),
      .stOut    (link[i]),
      .pairValid(pairValid[i])
    );
  end

  assign finalSt = link[0];
endmodule

// File: rtl/dr_cmp_ctrl.sv
module dr_cmp_ctrl
  import dr_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  cmpState_t        finalSt,
  input  logic [WIDTH-1:0] pairValid,
  output doneStrobes_t     strobes
);
  always_comb begin
    strobes.allValid = &pairValid;
    strobes.decided  = finalSt.gt | finalSt.lt;
    strobes.done     = strobes.decided | (finalSt.eq & strobes.allValid);
  end
endmodule

// File: rtl/dr_mag_cmp.sv
module dr_mag_cmp
  import dr_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] aTrue,
  input  logic [WIDTH-1:0] aFalse,
  input  logic [WIDTH-1:0] bTrue,
  input  logic [WIDTH-1:0] bFalse,
  output logic             ltOut,
  output logic             eqOut,
  output logic             gtOut,
  output logic             doneOut
);
  cmpState_t        finalSt;
  logic [WIDTH-1:0] pairValid;
  doneStrobes_t     strobes;

  dr_cmp_chain #(.WIDTH(WIDTH)) u_chain (
    .aTrue    (aTrue),
    .aFalse   (aFalse),
    .bTrue    (bTrue),
    .bFalse   (bFalse),
    .finalSt  (finalSt),
    .pairValid(pairValid)
  );

  dr_cmp_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .finalSt  (finalSt),
    .pairValid(pairValid),
    .strobes  (strobes)
  );

  assign gtOut   = finalSt.gt & strobes.decided;
  assign ltOut   = finalSt.lt & strobes.decided;
  assign eqOut   = finalSt.eq & strobes.allValid;
  assign doneOut = strobes.done;
endmodule

// File: rtl/dr_mag_cmp_chk.sv
module dr_mag_cmp_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] aTrue,
  input logic [WIDTH-1:0] aFalse,
  input logic [WIDTH-1:0] bTrue,
  input logic [WIDTH-1:0] bFalse,
  input logic             ltOut,
  input logic             eqOut,
  input logic             gtOut,
  input logic             doneOut
);
  logic [WIDTH-1:0] validBits;
  logic             everyValid;
  logic             noneValid;

  always_comb begin
    validBits  = (aTrue | aFalse) & (bTrue | bFalse);
    everyValid = &validBits;
    noneValid  = ~|{aTrue, aFalse, bTrue, bFalse};

    // R1
    spacer_idle_chk: assert (!noneValid || {ltOut, eqOut, gtOut, doneOut} == 4'b0)
      else $error("outputs active with all pairs at spacer");
    // R2
    full_done_chk: assert (!everyValid || doneOut)
      else $error("all pairs valid but no completion");
    // R4
    msb_first_chk: assert (!doneOut || validBits[WIDTH-1])
      else $error("completion with most significant pair at spacer");
    // R5
    eq_valid_chk: assert (!eqOut || (everyValid && aTrue == bTrue))
      else $error("equal reported with spacer or differing bits");
    // R6
    onehot_res_chk: assert ($onehot0({ltOut, eqOut, gtOut}))
      else $error("more than one result wire high");
    // R6
    done_match_chk: assert (doneOut == (ltOut | eqOut | gtOut))
      else $error("completion disagrees with result wires");
  end
endmodule

bind dr_mag_cmp dr_mag_cmp_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dr_mag_cmp_tb.sv
module dr_mag_cmp_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] aT, aF, bT, bF;
  logic lt, eq, gt, dn;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  dr_mag_cmp #(.WIDTH(W)) u_dut (
    .aTrue(aT), .aFalse(aF), .bTrue(bT), .bFalse(bF),
    .ltOut(lt), .eqOut(eq), .gtOut(gt), .doneOut(dn)
  );

  // Expected {lt,eq,gt} from the valid prefix starting at the top bit
  function automatic logic [2:0] model(input logic [W-1:0] a, b, m);
    for (int i = W - 1; i >= 0; i--) begin
      if (!m[i]) return 3'b000;
      if (a[i] && !b[i]) return 3'b001;
      if (!a[i] && b[i]) return 3'b100;
    end
    return 3'b010;
  endfunction

  function automatic logic [2:0] intCmp(input logic [W-1:0] a, b);
    if (a < b) return 3'b100;
    if (a == b) return 3'b010;
    return 3'b001;
  endfunction

  task automatic drive(input logic [W-1:0] a, b, m);
    aT = a & m;  aF = ~a & m;
    bT = b & m;  bF = ~b & m;
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({lt, eq, gt} !== exp || dn !== (|exp)) begin
      fails++;
      $display("FAIL %s: got lt/eq/gt/done=%b%b%b%b expected %b%b", req,
               lt, eq, gt, dn, exp, |exp);
    end
    checks++;
    if (!$onehot0({lt, eq, gt}) || dn !== (lt | eq | gt)) begin
      fails++;
      $display("FAIL R6: got lt/eq/gt/done=%b%b%b%b expected one-hot-or-zero with matching done",
               lt, eq, gt, dn);
    end
  endtask

  // mode 0: random order, 1: top bit first, 2: bottom bit first
  task automatic runCase(input logic [W-1:0] a, b, input int mode);
    int ord[W];
    logic [W-1:0] m = '0;
    logic [2:0] exp;
    logic [2:0] prevRes = 3'b000;
    logic prevDone = 1'b0;
    for (int i = 0; i < W; i++) ord[i] = (mode == 1) ? (W - 1 - i) : i;
    if (mode == 0)
      for (int i = W - 1; i > 0; i--) begin
        int j = $urandom_range(i, 0);
        int t = ord[i];
        ord[i] = ord[j];
        ord[j] = t;
      end
    @(posedge clk); #1; drive(a, b, m);
    @(negedge clk); check("R1", 3'b000);
    for (int s = 0; s < W; s++) begin
      @(posedge clk); #1;
      m[ord[s]] = 1'b1;
      drive(a, b, m);
      @(negedge clk);
      exp = model(a, b, m);
      check((exp == 3'b000) ? "R4" : "R3", exp);
      if (prevDone) begin
        checks++;
        if ({lt, eq, gt} !== prevRes) begin
          fails++;
          $display("FAIL R8: got %b expected %b held", {lt, eq, gt}, prevRes);
        end
      end
      prevDone = dn;
      prevRes = {lt, eq, gt};
    end
    check((a == b) ? "R5" : "R2", intCmp(a, b));
    for (int i = W - 1; i > 0; i--) begin
      int j = $urandom_range(i, 0);
      int t = ord[i];
      ord[i] = ord[j];
      ord[j] = t;
    end
    for (int s = 0; s < W; s++) begin
      @(posedge clk); #1;
      m[ord[s]] = 1'b0;
      drive(a, b, m);
      @(negedge clk);
      check("R7", model(a, b, m));
    end
    check("R7", 3'b000);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    aT = '0; aF = '0; bT = '0; bF = '0;
    #2;
    check("R1", 3'b000);
    // Directed corners
    runCase('1, '1, 0);                        // R5 equal, all ones
    runCase('0, '0, 2);                        // R5 equal, bottom first
    runCase('0, '1, 1);                        // R3 top bit decides at once
    runCase(8'h80, 8'h7f, 1);                  // R3 top bit differs
    runCase(8'h80, 8'h7f, 2);                  // R4 held until top bit
    runCase(8'h01, 8'h00, 1);                  // R4 bottom bit decides
    runCase(8'h5a, 8'h5b, 2);                  // R2 bottom bit less
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a = W'($urandom);
      logic [W-1:0] b = (n % 5 == 0) ? a : W'($urandom);
      runCase(a, b, n % 3);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got no completion expected finish before limit");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule